// File: doc/BRIEF.md
# SIMD Conditional Interrupt Return Sequencer

This block is the part of a program sequencer that carries out a conditional return from an interrupt service routine on a processor with two SIMD processing lanes, X and Y. It also records interrupt entries. Each entry sets a bit in the interrupt-mask pointer and counts one push onto the PC stack. When the serviced interrupt class saves status, the entry also counts one push onto the status stack.

A return request arrives together with the condition result from each lane, the SIMD-mode flag and the current top of the PC stack. The return is taken in SIMD mode only when both lanes agree. In scalar mode only lane X decides. A taken return has three effects, and they happen in the same cycle: a branch to the stacked address with a PC-stack pop, a status-stack pop when the serviced interrupt saved status, and the clearing of the serviced bit in the mask pointer. A return that is not taken has none of these effects. None of them occurs in part.

Top module: `simd_rti_seq`

## Requirements
- R1: In SIMD mode (`simd_en`=1), a return request is taken only when `cond_x` and `cond_y` are both 1. A taken request raises `br_req` for one cycle, on the clock edge after the request.
- R2: In scalar mode (`simd_en`=0), a return request is taken exactly when `cond_x` is 1, and `cond_y` is ignored.
- R3: On a taken return, `br_target` equals the `pc_top` value presented with the request.
- R4: A taken return asserts `pc_pop` in the same cycle as `br_req` whenever the tracked PC stack holds at least one entry.
- R5: A taken return asserts `sts_pop` in the same cycle as `br_req` only when the serviced interrupt index is a status-saving class and the status stack is not empty. The status-saving classes are the indices whose bit is set in `STS_MASK`; by default these are indices 4 to 7.
- R6: The serviced interrupt is the lowest-index set bit of `imaskp`. A taken return clears that bit alone.
- R7: A return request that is not taken leaves `br_req`, `pc_pop` and `sts_pop` low and leaves `imaskp` unchanged.
- R8: An entry (`ent_valid`=1) sets bit `ent_num` of `imaskp` on the next edge. It counts one PC-stack push, plus one status-stack push for a status-saving class. An entry applies alongside a return in the same cycle, and the clear is applied before the set.
- R9: A taken return with an empty PC stack sets the sticky flag `pc_uflow`, does not assert `pc_pop`, and leaves the stack count at zero. A later entry followed by a taken return therefore pops normally.
- R10: After reset, `imaskp`, both stack counts, `br_req`, `pc_pop`, `sts_pop`, `br_target` and `pc_uflow` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ent_valid | input | 1 | Interrupt entry accepted this cycle |
| ent_num | input | IW | Index of the interrupt being entered |
| rti_valid | input | 1 | Conditional return instruction this cycle |
| simd_en | input | 1 | SIMD mode: both lanes must agree |
| cond_x | input | 1 | Condition result in lane X |
| cond_y | input | 1 | Condition result in lane Y |
| pc_top | input | AW | Current top of the PC stack |
| br_req | output | 1 | Branch request for a taken return |
| br_target | output | AW | Branch target address |
| pc_pop | output | 1 | PC stack pop strobe |
| sts_pop | output | 1 | Status stack pop strobe |
| imaskp | output | NINT | Interrupt-mask pointer |
| pc_uflow | output | 1 | Sticky PC-stack underflow flag |

## Verification
The return is driven in SIMD mode with each of the four lane-condition pairs. The mixed pairs show that a single true lane never produces a partial effect: no mask clear and no pop without a branch. Scalar mode is driven with X false and Y true, and with X true and Y false, which shows that Y is ignored there. Two kinds of serviced interrupt are used, one that saves status and one that does not, to separate the cases for the status-stack pop. A mask with several set bits shows that only the lowest bit is cleared. Further cases cover a return on an empty stack, the cycle after that underflow, and an entry in the same cycle as a return.

// File: rtl/simd_rti_seq.sv
module simd_rti_seq #(
  parameter int AW = 16,
  parameter int NINT = 16,
  parameter int IW = $clog2(NINT),
  parameter int PCD = 30,
  parameter int STD = 15,
  parameter logic [NINT-1:0] STS_MASK = 16'h00F0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ent_valid,
  input  logic [IW-1:0]   ent_num,
  input  logic            rti_valid,
  input  logic            simd_en,
  input  logic            cond_x,
  input  logic            cond_y,
  input  logic [AW-1:0]   pc_top,
  output logic            br_req,
  output logic [AW-1:0]   br_target,
  output logic            pc_pop,
  output logic            sts_pop,
  output logic [NINT-1:0] imaskp,
  output logic            pc_uflow
);
  localparam int PCW = $clog2(PCD + 1);
  localparam int STW = $clog2(STD + 1);

  logic [PCW-1:0]  pc_cnt;
  logic [STW-1:0]  st_cnt;
  logic            svc_hit;
  logic [IW-1:0]   svc_idx;

  always_comb begin
    svc_hit = 1'b0;
    svc_idx = '0;
    for (int i = NINT - 1; i >= 0; i--) begin
      if (imaskp[i]) begin
        svc_hit = 1'b1;
        svc_idx = IW'(i);
      end
    end
  end

  wire take      = simd_en ? (cond_x & cond_y) : cond_x;
  wire fire      = rti_valid & take;
  wire pc_empty  = (pc_cnt == '0);
  wire pc_full   = (pc_cnt == PCW'(PCD));
  wire st_empty  = (st_cnt == '0);
  wire st_full   = (st_cnt == STW'(STD));
  wire do_pcpop  = fire & ~pc_empty;
  wire do_stpop  = fire & svc_hit & STS_MASK[svc_idx] & ~st_empty;
  wire pc_inc    = ent_valid & (~pc_full | do_pcpop);
  wire st_inc    = ent_valid & STS_MASK[ent_num] & (~st_full | do_stpop);

  wire [NINT-1:0] one     = {{(NINT-1){1'b0}}, 1'b1};
  wire [NINT-1:0] clr_vec = (fire & svc_hit) ? (one << svc_idx) : '0;
  wire [NINT-1:0] set_vec = ent_valid ? (one << ent_num) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_cnt    <= '0;
      st_cnt    <= '0;
      imaskp    <= '0;
      br_req    <= 1'b0;
      br_target <= '0;
      pc_pop    <= 1'b0;
      sts_pop   <= 1'b0;
      pc_uflow  <= 1'b0;
    end else begin
      pc_cnt   <= pc_cnt + PCW'(pc_inc) - PCW'(do_pcpop);
      st_cnt   <= st_cnt + STW'(st_inc) - STW'(do_stpop);
      imaskp   <= (imaskp & ~clr_vec) | set_vec;
      br_req   <= fire;
      pc_pop   <= do_pcpop;
      sts_pop  <= do_stpop;
      pc_uflow <= pc_uflow | (fire & pc_empty);
      if (fire) br_target <= pc_top;
    end
  end
endmodule

// File: rtl/simd_rti_chk.sv
module simd_rti_chk #(
  parameter int AW = 16,
  parameter int NINT = 16,
  parameter int IW = $clog2(NINT)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ent_valid,
  input logic [IW-1:0]   ent_num,
  input logic            rti_valid,
  input logic            simd_en,
  input logic            cond_x,
  input logic            cond_y,
  input logic [AW-1:0]   pc_top,
  input logic            br_req,
  input logic [AW-1:0]   br_target,
  input logic            pc_pop,
  input logic            sts_pop,
  input logic [NINT-1:0] imaskp,
  input logic            pc_uflow
);
  AST_SIMD_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    rti_valid && simd_en && cond_x && cond_y |=> br_req); // R1
  AST_SIMD_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    rti_valid && simd_en && !(cond_x && cond_y) |=> !br_req && !pc_pop && !sts_pop); // R1
  AST_SCALAR_X: assert property (@(posedge clk) disable iff (!rst_n)
    rti_valid && !simd_en |=> br_req == $past(cond_x)); // R2
  AST_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    rti_valid && cond_x && (cond_y || !simd_en) |=> br_target == $past(pc_top)); // R3
  AST_PCPOP_WITH_BR: assert property (@(posedge clk) disable iff (!rst_n)
    pc_pop |-> br_req); // R4
  AST_STSPOP_WITH_BR: assert property (@(posedge clk) disable iff (!rst_n)
    sts_pop |-> br_req); // R5
  AST_CLEAR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    rti_valid && cond_x && (cond_y || !simd_en) && !ent_valid && (imaskp != '0)
    |=> $countones(imaskp) + 1 == $countones($past(imaskp))); // R6
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ent_valid && !(rti_valid && cond_x && (cond_y || !simd_en)) |=> $stable(imaskp)); // R7
  AST_ENTRY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ent_valid |=> imaskp[$past(ent_num)]); // R8
  AST_UFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    pc_uflow |=> pc_uflow); // R9
endmodule

bind simd_rti_seq simd_rti_chk #(.AW(AW), .NINT(NINT), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_num(ent_num),
  .rti_valid(rti_valid), .simd_en(simd_en), .cond_x(cond_x), .cond_y(cond_y),
  .pc_top(pc_top), .br_req(br_req), .br_target(br_target), .pc_pop(pc_pop),
  .sts_pop(sts_pop), .imaskp(imaskp), .pc_uflow(pc_uflow)
);

// File: tb/simd_rti_seq_bench.sv
module simd_rti_seq_bench;
  localparam int AW = 16;
  localparam int NINT = 16;
  localparam int IW = 4;
  localparam logic [NINT-1:0] STS = 16'h00F0;

  logic clk = 0, rst_n = 0;
  logic ent_valid = 0, rti_valid = 0, simd_en = 0, cond_x = 0, cond_y = 0;
  logic [IW-1:0] ent_num = '0;
  logic [AW-1:0] pc_top = '0;
  logic br_req, pc_pop, sts_pop, pc_uflow;
  logic [AW-1:0] br_target;
  logic [NINT-1:0] imaskp;

  always #10 clk = ~clk;

  simd_rti_seq u_simd_rti_seq (
    .clk(clk), .rst_n(rst_n), .ent_valid(ent_valid), .ent_num(ent_num),
    .rti_valid(rti_valid), .simd_en(simd_en), .cond_x(cond_x), .cond_y(cond_y),
    .pc_top(pc_top), .br_req(br_req), .br_target(br_target), .pc_pop(pc_pop),
    .sts_pop(sts_pop), .imaskp(imaskp), .pc_uflow(pc_uflow)
  );

  typedef struct {
    logic br; logic [AW-1:0] tgt; logic pp; logic sp;
    logic [NINT-1:0] mask; logic uf; string tag;
  } item_t;

  item_t q[$];
  int tests = 0, fails = 0;
  bit done = 0;

  logic [NINT-1:0] m_mask = '0;
  int m_pc = 0, m_st = 0;
  logic m_uf = 0;

  task automatic cyc(input logic ent, input logic [IW-1:0] en, input logic rti,
                     input logic simd, input logic x, input logic y,
                     input logic [AW-1:0] pc, input string tag);
    item_t e;
    logic hit;
    int idx;
    hit = 0; idx = 0;
    for (int i = NINT - 1; i >= 0; i--) if (m_mask[i]) begin hit = 1; idx = i; end
    e.br   = rti && (simd ? (x && y) : x);
    e.tgt  = pc;
    e.pp   = e.br && (m_pc > 0);
    e.sp   = e.br && hit && STS[idx] && (m_st > 0);
    e.uf   = m_uf || (e.br && m_pc == 0);
    e.mask = m_mask;
    if (e.br && hit) e.mask[idx] = 1'b0;
    if (ent) e.mask[en] = 1'b1;
    e.tag  = tag;
    m_mask = e.mask;
    m_uf   = e.uf;
    m_pc   = m_pc + int'(ent) - int'(e.pp);
    m_st   = m_st + int'(ent && STS[en]) - int'(e.sp);
    ent_valid = ent; ent_num = en; rti_valid = rti;
    simd_en = simd; cond_x = x; cond_y = y; pc_top = pc;
    q.push_back(e);
    @(negedge clk);
    ent_valid = 0; rti_valid = 0;
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      item_t e;
      e = q.pop_front();
      tests++;
      if (br_req !== e.br || pc_pop !== e.pp || sts_pop !== e.sp ||
          imaskp !== e.mask || pc_uflow !== e.uf || (e.br && br_target !== e.tgt)) begin
        fails++;
        $display("FAIL %s: br=%b tgt=%h pp=%b sp=%b mask=%h uf=%b expected br=%b tgt=%h pp=%b sp=%b mask=%h uf=%b",
                 e.tag, br_req, br_target, pc_pop, sts_pop, imaskp, pc_uflow,
                 e.br, e.tgt, e.pp, e.sp, e.mask, e.uf);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    tests++;
    if (br_req !== 0 || pc_pop !== 0 || sts_pop !== 0 || imaskp !== '0 ||
        pc_uflow !== 0 || br_target !== '0) begin
      fails++;
      $display("FAIL R10 reset: br=%b pp=%b sp=%b mask=%h uf=%b tgt=%h expected all zero",
               br_req, pc_pop, sts_pop, imaskp, pc_uflow, br_target);
    end
    cyc(1, 4'd5, 0, 0, 0, 0, 16'h0, "R8 entry status class 5");
    cyc(1, 4'd2, 0, 0, 0, 0, 16'h0, "R8 entry plain class 2");
    cyc(0, 4'd0, 1, 1, 1, 0, 16'h1111, "R7 r1_ simd x only");
    cyc(0, 4'd0, 1, 1, 0, 1, 16'h2222, "R7 r1_ simd y only");
    cyc(0, 4'd0, 1, 1, 0, 0, 16'h3333, "R7 simd neither");
    cyc(0, 4'd0, 1, 1, 1, 1, 16'h1234, "R1 R3 R4 R5 R6 simd both plain class");
    cyc(0, 4'd0, 1, 0, 0, 1, 16'h4444, "R2 scalar y ignored");
    cyc(0, 4'd0, 1, 0, 1, 0, 16'hBEEF, "R2 R5 scalar x, status class pops");
    cyc(0, 4'd0, 0, 0, 0, 0, 16'h0, "R7 idle");
    cyc(0, 4'd0, 1, 1, 1, 1, 16'hCAFE, "R9 return on empty stack");
    cyc(0, 4'd0, 0, 0, 0, 0, 16'h0, "R9 underflow sticky");
    cyc(1, 4'd6, 0, 0, 0, 0, 16'h0, "R8 entry 6 after underflow");
    cyc(0, 4'd0, 1, 1, 1, 1, 16'h5A5A, "R9 r4_ pop after underflow");
    cyc(1, 4'd9, 0, 0, 0, 0, 16'h0, "R8 entry 9");
    cyc(1, 4'd3, 0, 0, 0, 0, 16'h0, "R8 entry 3");
    cyc(1, 4'd7, 0, 0, 0, 0, 16'h0, "R8 entry 7");
    cyc(0, 4'd0, 1, 0, 1, 1, 16'h0103, "R6 lowest of 3,7,9 cleared");
    cyc(1, 4'd1, 1, 1, 1, 1, 16'h0207, "R8 R6 R5 entry with return");
    cyc(0, 4'd0, 1, 1, 1, 0, 16'h0F0F, "R7 mask unchanged");
    cyc(0, 4'd0, 1, 0, 1, 0, 16'h0301, "R6 clear bit 1");
    cyc(0, 4'd0, 1, 1, 1, 1, 16'h0409, "R5 plain class 9 no status pop");
    cyc(0, 4'd0, 0, 0, 0, 0, 16'h0, "R7 final idle");
    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule